// File: doc/BRIEF.md
# Lockable Identification Page Controller

This block runs a 256-byte identification page that sits next to the main array of a serial EEPROM. A byte-level I2C slave front end feeds it. The front end reports start and stop conditions and every byte it receives from the master. For each received byte the block replies with an ACK or NoACK decision. During read transfers it presents the next page byte on a valid/ready stream.

The page has its own device-type code. Select bytes whose upper nibble differs from that code are left to other logic. After the select byte the master sends two address bytes:

- One bit in the first address byte chooses between a page write and a one-way lock command.
- The second address byte sets the byte offset inside the page.

Written bytes are first collected in a staging copy. They reach the page only when a stop follows a completed data byte. This is why a write cut short by a new start changes nothing. Masters use that property to probe the lock state: they send one data byte, watch its ACK, and then abort with a start. The lock is sticky. Only the block's reset clears it, and that reset stands in for the loss of non-volatile contents.

Back-pressure rules:

- **Receive side.** It has no ready signal. The block takes one byte in any cycle where `rx_valid_i` is high and no start or stop is signalled.
- **Transmit side.** `tx_data_o` holds steady while `tx_valid_o` is high. A cycle in which both `tx_valid_o` and `tx_ready_i` are high consumes the byte and advances the offset.

Top module: `idp_ctrl`

## Requirements
- R1: After reset the page is unlocked, every page byte reads FFh, `tx_valid_o` and `ack_valid_o` are low, and the offset is 00h.
- R2: In the first byte after a start, bits 7..4 equal to 1011b give an ACK. Bit 0 then selects read (1) or write (0), and bits 3..1 are ignored. Any other type nibble gives a NoACK, and every byte up to the next start is NoACKed and ignored.
- R3: Both address bytes of a write-type command are ACKed. Bit 2 of the first address byte picks the lock command (1) or a page write (0), and its other bits are ignored. The second address byte loads the offset.
- R4: While unlocked, each page-write data byte is ACKed and staged at the current offset. The offset then increments, wrapping from FFh to 00h. A stop after at least one accepted data byte copies all staged bytes into the page.
- R5: A start that arrives before the stop discards every staged byte, and the page keeps its contents. An unlocked page therefore answers a one-byte probe with ACK, a locked page answers it with NoACK, and the probe writes nothing.
- R6: The first data byte of a lock command is ACKed while unlocked. A following stop sets the lock only if bit 1 of that byte is 1, and its other bits are ignored. Any further data byte in the same command is NoACKed and cancels the pending lock.
- R7: Once locked, page-write data bytes and lock data bytes are NoACKed and the page does not change. The lock never clears except by reset.
- R8: A read-type select byte raises `tx_valid_o` with `tx_data_o` equal to the page byte at the current offset. Each handshake advances the offset with wrap. The offset loaded by an earlier address phase survives a repeated start, which gives a random read.
- R9: `ack_valid_o` pulses in the cycle after each accepted byte, with `ack_o` carrying the decision. `ack_o` is low whenever `ack_valid_o` is low.
- R10: A start or a stop ends a read, and `tx_valid_o` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also clears lock and page |
| start_i | input | 1 | Start or repeated start seen on the bus (one-cycle pulse) |
| stop_i | input | 1 | Stop seen on the bus (one-cycle pulse) |
| rx_valid_i | input | 1 | A byte from the master is present |
| rx_data_i | input | 8 | Received byte |
| ack_valid_o | output | 1 | ACK decision available for the last received byte |
| ack_o | output | 1 | 1 = ACK, 0 = NoACK |
| tx_valid_o | output | 1 | Read byte available |
| tx_ready_i | input | 1 | Front end consumes the read byte |
| tx_data_o | output | 8 | Page byte at the current offset |
| locked_o | output | 1 | Lock flag |

## Verification
The bench aims at the following corner cases:

- **Truncated probe.** A design that commits on every data byte would overwrite the page there.
- **Lock data byte with bit 1 clear, and lock command with a second data byte.** A design that decodes the whole byte, or ignores the extra byte, would lock when it should not.
- **Page write across FFh.** A design that does not wrap would write outside the page.
- **Random read after a dummy write.** A design that resets the offset on start would return the wrong byte.
- **Write and lock commands sent after locking.** A design whose lock is not sticky would still ACK them and change the page.

// File: rtl/idp_pkg.sv
package idp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_AHI, ST_ALO, ST_WR, ST_LOCK, ST_RD, ST_SKIP
  } idp_state_e;
endpackage

// File: rtl/idp_page_store.sv
module idp_page_store #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [7:0]        data_i,
  input  logic              clr_i,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] rd_off_i,
  output logic [7:0]        rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]       page_q  [DEPTH];
  logic [7:0]       stage_q [DEPTH];
  logic [DEPTH-1:0] mask_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    // committed byte: survives everything but reset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     page_q[g] <= 8'hFF;
      else if (commit_i && mask_q[g]) page_q[g] <= stage_q[g];
    end
    always_ff @(posedge clk) begin
      if (we_i && off_i == ADDR_W'(g)) stage_q[g] <= data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (clr_i) mask_q <= '0;
    else if (we_i)  mask_q[off_i] <= 1'b1;
  end

  assign rd_data_o = page_q[rd_off_i];

  // R5/R7: page byte under the read offset only changes on a commit
  p_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> (rd_off_i != $past(rd_off_i)) || (rd_data_o == $past(rd_data_o)));
  // R4: a commit always has at least one staged byte behind it
  p_commit_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> (mask_q != '0));
endmodule

// File: rtl/idp_cmd_fsm.sv
module idp_cmd_fsm
  import idp_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter logic [3:0] TYPE_CODE = 4'b1011,
  parameter int         SEL_BIT   = 2,
  parameter int         LOCK_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              tx_ready_i,
  output logic              ack_valid_o,
  output logic              ack_o,
  output logic              tx_valid_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              stg_we_o,
  output logic              stg_clr_o,
  output logic              commit_o,
  output logic              locked_o
);
  idp_state_e        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic sel_q, sel_d, seen_q, seen_d, pend_q, pend_d, lock_q, lock_d;
  logic ack_q, ack_d, ackv_q;
  logic take_byte;

  assign take_byte = rx_valid_i & ~start_i & ~stop_i;

  always_comb begin
    state_d = state_q; ptr_d = ptr_q; sel_d = sel_q;
    seen_d = seen_q; pend_d = pend_q; lock_d = lock_q; ack_d = 1'b0;
    if (start_i) begin
      state_d = ST_SEL; seen_d = 1'b0; pend_d = 1'b0;
    end else if (stop_i) begin
      if (state_q == ST_LOCK && pend_q && !lock_q) lock_d = 1'b1;
      state_d = ST_IDLE; seen_d = 1'b0; pend_d = 1'b0;
    end else begin
      if (state_q == ST_RD && tx_ready_i) ptr_d = ptr_q + ADDR_W'(1);
      if (rx_valid_i) begin
        unique case (state_q)
          ST_SEL: begin
            if (rx_data_i[7:4] == TYPE_CODE) begin
              ack_d   = 1'b1;
              state_d = rx_data_i[0] ? ST_RD : ST_AHI;
            end else begin
              state_d = ST_SKIP;
            end
          end
          ST_AHI: begin
            ack_d = 1'b1; sel_d = rx_data_i[SEL_BIT]; state_d = ST_ALO;
          end
          ST_ALO: begin
            ack_d   = 1'b1;
            ptr_d   = rx_data_i[ADDR_W-1:0];
            state_d = sel_q ? ST_LOCK : ST_WR;
          end
          ST_WR: begin
            ptr_d = ptr_q + ADDR_W'(1);
            if (!lock_q) begin ack_d = 1'b1; seen_d = 1'b1; end
          end
          ST_LOCK: begin
            if (!lock_q && !seen_q) begin
              ack_d = 1'b1; seen_d = 1'b1; pend_d = rx_data_i[LOCK_BIT];
            end else begin
              pend_d = 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; ptr_q <= '0; sel_q <= 1'b0; seen_q <= 1'b0;
      pend_q <= 1'b0; lock_q <= 1'b0; ack_q <= 1'b0; ackv_q <= 1'b0;
    end else begin
      state_q <= state_d; ptr_q <= ptr_d; sel_q <= sel_d; seen_q <= seen_d;
      pend_q <= pend_d; lock_q <= lock_d; ack_q <= ack_d; ackv_q <= take_byte;
    end
  end

  assign ack_valid_o = ackv_q;
  assign ack_o       = ack_q;
  assign tx_valid_o  = (state_q == ST_RD);
  assign ptr_o       = ptr_q;
  assign locked_o    = lock_q;
  assign stg_we_o    = take_byte && state_q == ST_WR && !lock_q;
  assign stg_clr_o   = start_i | stop_i;
  assign commit_o    = stop_i && !start_i && state_q == ST_WR && seen_q;

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  p_locked_wr_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_byte && state_q == ST_WR && lock_q) |=> (ack_valid_o && !ack_o));
  p_foreign_nack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_byte && state_q == ST_SEL && rx_data_i[7:4] != TYPE_CODE) |=> !ack_o);
  p_ack_qualified_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid_o |-> !ack_o);
  p_tx_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i || stop_i) |=> !tx_valid_o);
  p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && tx_ready_i && (&ptr_q) && !start_i && !stop_i) |=> (ptr_q == '0));
endmodule

// File: rtl/idp_ctrl.sv
module idp_ctrl #(
  parameter int         ADDR_W    = 8,
  parameter logic [3:0] TYPE_CODE = 4'b1011,
  parameter int         SEL_BIT   = 2,
  parameter int         LOCK_BIT  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  output logic       ack_valid_o,
  output logic       ack_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i,
  output logic [7:0] tx_data_o,
  output logic       locked_o
);
  logic [ADDR_W-1:0] ptr;
  logic stg_we, stg_clr, commit;

  idp_cmd_fsm #(
    .ADDR_W(ADDR_W), .TYPE_CODE(TYPE_CODE), .SEL_BIT(SEL_BIT), .LOCK_BIT(LOCK_BIT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .tx_ready_i(tx_ready_i),
    .ack_valid_o(ack_valid_o), .ack_o(ack_o), .tx_valid_o(tx_valid_o),
    .ptr_o(ptr), .stg_we_o(stg_we), .stg_clr_o(stg_clr), .commit_o(commit),
    .locked_o(locked_o)
  );

  idp_page_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(stg_we), .off_i(ptr), .data_i(rx_data_i),
    .clr_i(stg_clr), .commit_i(commit), .rd_off_i(ptr), .rd_data_o(tx_data_o)
  );
endmodule

// File: tb/idp_ctrl_tb.sv
module idp_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, rx_valid_i = 0, tx_ready_i = 0;
  logic [7:0] rx_data_i = 0;
  logic ack_valid_o, ack_o, tx_valid_o, locked_o;
  logic [7:0] tx_data_o;

  always #10 clk = ~clk;

  idp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .ack_valid_o(ack_valid_o),
    .ack_o(ack_o), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
    .tx_data_o(tx_data_o), .locked_o(locked_o)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit started = 0, timed_out = 0;

  // behavioural reference: 0 idle 1 select 2 addr-hi 3 addr-lo 4 write 5 lock 6 read 7 skip
  int m_mode, m_ptr;
  int m_page [256];
  int m_stage [int];
  bit m_lock, m_sel, m_seen, m_pend;
  int e_av, e_ack, e_tv, e_td, e_lk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_ptr = 0; m_lock = 0; m_sel = 0; m_seen = 0; m_pend = 0;
      foreach (m_page[k]) m_page[k] = 8'hFF;
      m_stage.delete();
      e_av = 0; e_ack = 0;
    end else begin
      started = 1;
      e_av = 0; e_ack = 0;
      if (start_i) begin
        m_stage.delete(); m_mode = 1; m_seen = 0; m_pend = 0;
      end else if (stop_i) begin
        if (m_mode == 4 && m_seen) foreach (m_stage[k]) m_page[k] = m_stage[k];
        if (m_mode == 5 && m_pend && !m_lock) m_lock = 1;
        m_stage.delete(); m_mode = 0; m_seen = 0; m_pend = 0;
      end else begin
        if (m_mode == 6 && tx_ready_i) m_ptr = (m_ptr + 1) % 256;
        if (rx_valid_i) begin
          e_av = 1;
          case (m_mode)
            1: if (rx_data_i[7:4] == 4'b1011) begin
                 e_ack = 1; m_mode = rx_data_i[0] ? 6 : 2;
               end else m_mode = 7;
            2: begin e_ack = 1; m_sel = rx_data_i[2]; m_mode = 3; end
            3: begin e_ack = 1; m_ptr = rx_data_i; m_mode = m_sel ? 5 : 4; end
            4: begin
                 if (!m_lock) begin e_ack = 1; m_seen = 1; m_stage[m_ptr] = rx_data_i; end
                 m_ptr = (m_ptr + 1) % 256;
               end
            5: if (!m_lock && !m_seen) begin
                 e_ack = 1; m_seen = 1; m_pend = rx_data_i[1];
               end else m_pend = 0;
            default: ;
          endcase
        end
      end
    end
    e_tv = (m_mode == 6); e_td = m_page[m_ptr]; e_lk = m_lock;
  end

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    cmp("ack_valid", ack_valid_o, e_av);
    cmp("ack", ack_o, e_ack);
    cmp("locked", locked_o, e_lk);
    cmp("tx_valid", tx_valid_o, e_tv);
    cmp("tx_data", tx_data_o, e_td);
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic do_start; @(negedge clk); start_i = 1; @(negedge clk); start_i = 0; endtask
  task automatic do_stop;  @(negedge clk); stop_i = 1;  @(negedge clk); stop_i = 0; idle(1); endtask
  task automatic send(logic [7:0] b);
    @(negedge clk); rx_valid_i = 1; rx_data_i = b;
    @(negedge clk); rx_valid_i = 0; idle(1);
  endtask
  task automatic take; @(negedge clk); tx_ready_i = 1; @(negedge clk); tx_ready_i = 0; endtask
  task automatic wr_head(logic [7:0] sel, logic [7:0] hi, logic [7:0] lo);
    do_start(); send(sel); send(hi); send(lo);
  endtask
  task automatic rd_from(logic [7:0] off, int n);
    wr_head(8'hB0, 8'h00, off); do_start(); send(8'hB1);
    repeat (n) take();
    do_stop();
  endtask

  task automatic run_all;
    cur_req = "R1"; idle(4);
    cur_req = "R2"; do_start(); send(8'hA0); send(8'h00); send(8'h10); send(8'h55); do_stop();
    cur_req = "R3"; wr_head(8'hBE, 8'hFB, 8'h10); send(8'h11); send(8'h22); send(8'h33); do_stop();
    cur_req = "R8"; rd_from(8'h10, 4);
    cur_req = "R4"; wr_head(8'hB0, 8'h00, 8'hFE);
    send(8'hA1); send(8'hA2); send(8'hA3); send(8'hA4); send(8'hA5); do_stop();
    cur_req = "R8"; rd_from(8'hFD, 6);
    cur_req = "R10"; wr_head(8'hB0, 8'h00, 8'h11); do_start(); send(8'hB1); take(); do_start(); idle(2); do_stop();
    cur_req = "R5"; wr_head(8'hB0, 8'h00, 8'h20); send(8'h77); do_start(); do_stop();
    rd_from(8'h20, 1);
    cur_req = "R6"; wr_head(8'hB0, 8'h04, 8'h00); send(8'hFD); do_stop();
    wr_head(8'hB0, 8'h04, 8'h00); send(8'h02); send(8'h02); do_stop();
    wr_head(8'hB0, 8'h04, 8'h00); send(8'h02); do_start(); do_stop();
    wr_head(8'hB0, 8'hFF, 8'h55); send(8'h02); do_stop();
    cur_req = "R7"; wr_head(8'hB0, 8'h00, 8'h10); send(8'h99); send(8'h98); do_stop();
    wr_head(8'hB0, 8'h00, 8'h40); send(8'h01); do_start(); do_stop();
    wr_head(8'hB0, 8'h04, 8'h00); send(8'h02); do_stop();
    rd_from(8'h10, 3);
    cur_req = "R9"; idle(3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    fork
      run_all();
      begin repeat (150000) @(posedge clk); timed_out = 1; end
    join_any
    disable fork;
    if (timed_out) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements): actual expired, expected finished");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule